// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table that sits in memory. A requester presents the virtual address together with the physical base of the top-level (directory) table. The walker splits the address into three fields:

- a 10-bit directory index (bits 31:22);
- a 10-bit leaf index (bits 21:12);
- a 12-bit byte offset within a 4 KB page (bits 11:0).

The walker then makes two dependent word reads through a simple memory request/response port. The first read fetches the directory entry, which locates a leaf table. The second read fetches the leaf entry, which holds the page frame.

Every table entry is one 32-bit word, so an index is multiplied by 4 to give its byte position inside a table. Bit 0 of an entry is its valid flag. Bits 31:12 hold a page number: the leaf-table base for a directory entry, or the frame for a leaf entry. Bits 11:1 are ignored. If either entry is invalid, the walker ends the walk with a one-cycle fault pulse and a level flag, and gives no translation. Otherwise it gives a one-cycle done pulse with the frame joined to the 12-bit offset. The block does not cache translations, handle faults, check permissions or write entries back.

The walker is a state machine with these states:

| State | Meaning |
|---|---|
| ST_IDLE | Ready for a new request |
| ST_MREQ | Directory read issued, waiting for acceptance |
| ST_MWAIT | Waiting for the directory word |
| ST_SREQ | Leaf read issued, waiting for acceptance |
| ST_SWAIT | Waiting for the leaf word |
| ST_DONE | One-cycle done pulse |
| ST_FAULT | One-cycle fault pulse |

It moves between them as follows:

| From | Condition | To |
|---|---|---|
| ST_IDLE | request seen | ST_MREQ |
| ST_MREQ | read accepted | ST_MWAIT |
| ST_MWAIT | response, entry valid | ST_SREQ |
| ST_MWAIT | response, entry invalid | ST_FAULT |
| ST_SREQ | read accepted | ST_SWAIT |
| ST_SWAIT | response, entry valid | ST_DONE |
| ST_SWAIT | response, entry invalid | ST_FAULT |
| ST_DONE | always | ST_IDLE |
| ST_FAULT | always | ST_IDLE |

Top module: `pt2_walker`

## Requirements
- R1: After reset, req_ready is 1, and mem_req_valid, walk_done and walk_fault are 0.
- R2: The first read goes to address {root_base[31:12], vaddr[31:22], 2'b00}; the low 12 bits of root_base are ignored.
- R3: Once raised, mem_req_valid stays high with an unchanged mem_req_addr until it is taken on an edge with mem_req_ready high.
- R4: A directory word with bit 0 = 0 ends the walk with a one-cycle walk_fault and fault_level = 0, and no second read is issued.
- R5: The second read goes to address {directory_word[31:12], vaddr[21:12], 2'b00}.
- R6: A leaf word with bit 0 = 0 ends the walk with a one-cycle walk_fault and fault_level = 1.
- R7: A valid leaf word gives a one-cycle walk_done with walk_paddr = {leaf_word[31:12], vaddr[11:0]}; leaf bits 11:1 do not affect the result.
- R8: req_ready is high only in ST_IDLE; a request presented while a walk is in progress is ignored.
- R9: mem_rsp_valid is taken only while a read is outstanding; a response in any other state has no effect.
- R10: walk_done and walk_fault are never high together, and each lasts exactly one cycle.
- R11: With mem_req_ready held high and each response arriving one cycle after acceptance, walk_done rises on the fourth rising edge after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical base of the directory table |
| mem_req_valid | output | 1 | Memory word-read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| walk_done | output | 1 | One-cycle pulse: translation ready |
| walk_fault | output | 1 | One-cycle pulse: invalid entry found |
| fault_level | output | 1 | Level of the faulting entry: 0 directory, 1 leaf |
| walk_paddr | output | 32 | Translated physical address, valid with walk_done |

## Verification
The assertions assume that memory answers each accepted read with exactly one response, at least one cycle after acceptance and never while another read is pending. They also assume that requests and responses change only between clock edges. The bench's memory model keeps a single pending read, with a response delay of one to three cycles. It sends stray responses only while the walker is idle, and it changes all inputs on the falling edge. Stray requests during a walk carry random addresses and bases, so any wrong capture would show in the addresses the walker issues.

// File: rtl/pt2_walk_pkg.sv
package pt2_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MREQ,
        ST_MWAIT,
        ST_SREQ,
        ST_SWAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

endpackage

// File: rtl/pt2_walk_pte_dec.sv
module pt2_walk_pte_dec #(
    parameter int PTE_W = 32,
    parameter int OFF_W = 12
) (
    input  logic [PTE_W-1:0]       raw,
    output logic                   ent_valid,
    output logic [PTE_W-OFF_W-1:0] ent_ppn
);

    // Attribute bits between the valid flag and the page number are not decoded.
    logic attr_unused;

    assign ent_valid   = raw[0];
    assign ent_ppn     = raw[PTE_W-1:OFF_W];
    assign attr_unused = ^raw[OFF_W-1:1];

endmodule

// File: rtl/pt2_walk_datapath.sv
module pt2_walk_datapath #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int IDX_W     = 10,
    parameter int OFF_W     = 12,
    parameter int ENT_SHIFT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_req,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [PA_W-1:0]       root_base,
    input  logic                  cap_tbl,
    input  logic                  cap_frame,
    input  logic [PA_W-OFF_W-1:0] ent_ppn,
    input  logic                  sel_sec,
    output logic [PA_W-1:0]       mem_addr,
    output logic [PA_W-1:0]       paddr
);

    localparam int PPN_W = PA_W - OFF_W;
    localparam int MHI   = VA_W - 1;
    localparam int SHI   = VA_W - IDX_W - 1;

    logic [VA_W-1:0]  va_q;
    logic [PPN_W-1:0] root_q;
    logic [PPN_W-1:0] tbl_q;
    logic [PPN_W-1:0] frame_q;
    logic [PA_W-1:0]  lvl_addr [2];
    logic             root_unused;

    assign root_unused = ^root_base[OFF_W-1:0];

    function automatic logic [PA_W-1:0] ent_addr(input logic [PPN_W-1:0] tb,
                                                 input logic [IDX_W-1:0] ix);
        logic [PA_W-1:0] scaled;
        scaled = PA_W'(ix) << ENT_SHIFT;
        return {tb, {OFF_W{1'b0}}} | scaled;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            root_q  <= '0;
            tbl_q   <= '0;
            frame_q <= '0;
        end else begin
            if (cap_req) begin
                va_q   <= req_vaddr;
                root_q <= root_base[PA_W-1:OFF_W];
            end
            if (cap_tbl)
                tbl_q <= ent_ppn;
            if (cap_frame)
                frame_q <= ent_ppn;
        end
    end

    // One address former per table level.
    for (genvar g = 0; g < 2; g++) begin : g_level
        if (g == 0) begin : g_dir
            assign lvl_addr[g] = ent_addr(root_q, va_q[MHI -: IDX_W]);
        end else begin : g_leaf
            assign lvl_addr[g] = ent_addr(tbl_q, va_q[SHI -: IDX_W]);
        end
    end

    assign mem_addr = sel_sec ? lvl_addr[1] : lvl_addr[0];
    assign paddr    = {frame_q, va_q[OFF_W-1:0]};

    // R5
    leaf_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_tbl |=> (sel_sec && mem_addr[PA_W-1:OFF_W] == $past(ent_ppn)));

    // R7
    paddr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_frame |=> (paddr[PA_W-1:OFF_W] == $past(ent_ppn) &&
                       paddr[OFF_W-1:0] == $past(va_q[OFF_W-1:0])));

endmodule

// File: rtl/pt2_walk_fsm.sv
module pt2_walk_fsm
    import pt2_walk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    input  logic mem_req_ready,
    output logic mem_req_valid,
    input  logic mem_rsp_valid,
    input  logic ent_valid,
    output logic sel_sec,
    output logic cap_req,
    output logic cap_tbl,
    output logic cap_frame,
    output logic done,
    output logic fault,
    output logic fault_level
);

    walk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_MREQ;
            ST_MREQ:  if (mem_req_ready) state_d = ST_MWAIT;
            ST_MWAIT: if (mem_rsp_valid) state_d = ent_valid ? ST_SREQ : ST_FAULT;
            ST_SREQ:  if (mem_req_ready) state_d = ST_SWAIT;
            ST_SWAIT: if (mem_rsp_valid) state_d = ent_valid ? ST_DONE : ST_FAULT;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            fault_level <= 1'b0;
        end else begin
            state_q <= state_d;
            if (mem_rsp_valid && !ent_valid) begin
                if (state_q == ST_MWAIT) fault_level <= 1'b0;
                if (state_q == ST_SWAIT) fault_level <= 1'b1;
            end
        end
    end

    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        sel_sec       = 1'b0;
        cap_req       = 1'b0;
        cap_tbl       = 1'b0;
        cap_frame     = 1'b0;
        done          = 1'b0;
        fault         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                cap_req   = req_valid;
            end
            ST_MREQ:  mem_req_valid = 1'b1;
            ST_MWAIT: cap_tbl = mem_rsp_valid && ent_valid;
            ST_SREQ: begin
                mem_req_valid = 1'b1;
                sel_sec       = 1'b1;
            end
            ST_SWAIT: cap_frame = mem_rsp_valid && ent_valid;
            ST_DONE:  done  = 1'b1;
            ST_FAULT: fault = 1'b1;
            default:  req_ready = 1'b0;
        endcase
    end

    // R4
    dir_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MWAIT && mem_rsp_valid && !ent_valid) |=>
            (fault && !fault_level));

    // R6
    leaf_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWAIT && mem_rsp_valid && !ent_valid) |=>
            (fault && fault_level));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

endmodule

// File: rtl/pt2_walker.sv
module pt2_walker #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int IDX_W     = 10,
    parameter int OFF_W     = 12,
    parameter int ENT_SHIFT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [PA_W-1:0] root_base,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PA_W-1:0] mem_rsp_data,
    output logic            walk_done,
    output logic            walk_fault,
    output logic            fault_level,
    output logic [PA_W-1:0] walk_paddr
);

    localparam int PPN_W = PA_W - OFF_W;

    logic             ent_valid;
    logic [PPN_W-1:0] ent_ppn;
    logic             sel_sec;
    logic             cap_req;
    logic             cap_tbl;
    logic             cap_frame;

    pt2_walk_pte_dec #(
        .PTE_W (PA_W),
        .OFF_W (OFF_W)
    ) u_dec (
        .raw       (mem_rsp_data),
        .ent_valid (ent_valid),
        .ent_ppn   (ent_ppn)
    );

    pt2_walk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_valid     (ent_valid),
        .sel_sec       (sel_sec),
        .cap_req       (cap_req),
        .cap_tbl       (cap_tbl),
        .cap_frame     (cap_frame),
        .done          (walk_done),
        .fault         (walk_fault),
        .fault_level   (fault_level)
    );

    pt2_walk_datapath #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .IDX_W     (IDX_W),
        .OFF_W     (OFF_W),
        .ENT_SHIFT (ENT_SHIFT)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_req   (cap_req),
        .req_vaddr (req_vaddr),
        .root_base (root_base),
        .cap_tbl   (cap_tbl),
        .cap_frame (cap_frame),
        .ent_ppn   (ent_ppn),
        .sel_sec   (sel_sec),
        .mem_addr  (mem_req_addr),
        .paddr     (walk_paddr)
    );

    // R3
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr)));

endmodule

// File: tb/pt2_walker_tb.sv
module pt2_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [31:0] root_base;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        walk_done;
    logic        walk_fault;
    logic        fault_level;
    logic [31:0] walk_paddr;

    always #10 clk = ~clk;

    pt2_walker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .root_base     (root_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .walk_done     (walk_done),
        .walk_fault    (walk_fault),
        .fault_level   (fault_level),
        .walk_paddr    (walk_paddr)
    );

    int unsigned mem [int unsigned];
    int unsigned job_va [$];
    int unsigned job_base [$];
    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int          step;
    int unsigned m_va, m_base, m_tbl, m_frame;
    bit          m_lvl;

    function automatic int unsigned rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic int unsigned va_of(input int unsigned mi, input int unsigned si,
                                          input int unsigned off);
        return (mi << 22) | (si << 12) | off;
    endfunction

    function automatic int unsigned dir_addr(input int unsigned va, input int unsigned base);
        return (base & 32'hFFFFF000) | ((va >> 22) << 2);
    endfunction

    function automatic int unsigned leaf_addr(input int unsigned va, input int unsigned ent);
        return (ent & 32'hFFFFF000) | (((va >> 12) & 32'h3FF) << 2);
    endfunction

    task automatic chk(input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void add_job(input int unsigned va, input int unsigned base);
        job_va.push_back(va);
        job_base.push_back(base);
    endfunction

    initial begin
        int unsigned baseA, baseB;
        int          n_jobs, jidx, done_jobs, cyc, acc_cyc, gap, pend_cnt;
        int unsigned pend_addr;
        bit          fast, spur_prev, spur_now;
        string       t;

        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; root_base = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;

        baseA = 32'h0010_0000;
        baseB = 32'h0040_0ABC;          // low bits must be ignored (R2)
        mem[dir_addr(va_of(1, 0, 0), baseA)]     = 32'h0020_0001;
        mem[dir_addr(va_of(10'h3FF, 0, 0), baseA)] = 32'h0030_0001;
        mem[dir_addr(va_of(2, 0, 0), baseA)]     = 32'h0050_0FFE;  // invalid
        mem[dir_addr(va_of(1, 0, 0), baseB)]     = 32'h0030_0FFF;
        mem[leaf_addr(va_of(0, 5, 0), 32'h0020_0000)]      = 32'h1234_5001;
        mem[leaf_addr(va_of(0, 10'h3FF, 0), 32'h0020_0000)] = 32'hABCD_EFFF;
        mem[leaf_addr(va_of(0, 6, 0), 32'h0020_0000)]      = 32'h5555_5FFE; // invalid
        mem[leaf_addr(va_of(0, 0, 0), 32'h0030_0000)]      = 32'h0000_1001;

        add_job(va_of(1, 5, 12'h123), baseA);
        add_job(va_of(1, 10'h3FF, 12'hFFF), baseA);
        add_job(va_of(2, 7, 12'h010), baseA);
        add_job(va_of(1, 6, 12'h000), baseA);
        add_job(va_of(10'h3FF, 0, 12'h800), baseA);
        add_job(va_of(1, 0, 12'h001), baseB);
        add_job(va_of(10'h100, 3, 12'h456), baseA);
        n_jobs = job_va.size();

        repeat (3) begin
            @(negedge clk);
            chk("R1", "req_ready in reset", req_ready, 1);
            chk("R1", "mem_req_valid in reset", mem_req_valid, 0);
            chk("R1", "walk_done in reset", walk_done, 0);
            chk("R1", "walk_fault in reset", walk_fault, 0);
        end
        rst_n = 1'b1;

        step = 0; m_va = 0; m_base = 0; m_tbl = 0; m_frame = 0; m_lvl = 0;
        jidx = 0; done_jobs = 0; cyc = 0; acc_cyc = 0; gap = 1;
        pend_cnt = 0; pend_addr = 0; spur_prev = 0;

        while (!(done_jobs == 2 * n_jobs && step == 0)) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                chk("R11", "watchdog expired", 1, 0);
                break;
            end
            fast = (done_jobs < n_jobs);

            // compare against the model
            chk("R8", "req_ready", req_ready, (step == 0));
            t = (step == 1) ? "R2" : ((step == 3) ? "R5" : "R4");
            chk(t, "mem_req_valid", mem_req_valid, (step == 1 || step == 3));
            if (step == 1) chk("R2", "directory addr", mem_req_addr, dir_addr(m_va, m_base));
            if (step == 3) chk("R5", "leaf addr", mem_req_addr, leaf_addr(m_va, m_tbl));
            t = spur_prev ? "R9" : "R7";
            chk(t, "walk_done", walk_done, (step == 5));
            t = spur_prev ? "R9" : (m_lvl ? "R6" : "R4");
            chk(t, "walk_fault", walk_fault, (step == 6));
            chk("R10", "done and fault together", walk_done & walk_fault, 0);
            if (step == 5) begin
                chk("R7", "walk_paddr", walk_paddr,
                    (m_frame & 32'hFFFFF000) | (m_va & 32'hFFF));
                if (fast) chk("R11", "cycles to done", cyc - acc_cyc, 5);
            end
            if (step == 6) chk(m_lvl ? "R6" : "R4", "fault_level", fault_level, m_lvl);

            // memory response
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = $urandom;
            spur_now = 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(pend_addr);
                end
            end else if (step == 0 && !fast && ($urandom % 3 == 0)) begin
                mem_rsp_valid = 1'b1;          // stray response (R9)
                mem_rsp_data  = 32'hFFFF_F001;
                spur_now = 1'b1;
            end

            // memory acceptance
            mem_req_ready = fast ? 1'b1 : ($urandom % 3 != 0);
            if ((step == 1 || step == 3) && mem_req_ready) begin
                pend_addr = (step == 1) ? dir_addr(m_va, m_base) : leaf_addr(m_va, m_tbl);
                pend_cnt  = fast ? 1 : 1 + int'($urandom % 3);
            end

            // translation requests
            if (step == 0) begin
                if (gap == 0 && jidx < 2 * n_jobs) begin
                    req_valid = 1'b1;
                    req_vaddr = job_va[jidx % n_jobs];
                    root_base = job_base[jidx % n_jobs];
                    acc_cyc   = cyc;
                    jidx++;
                    gap = fast ? 1 : int'($urandom % 3);
                end else begin
                    req_valid = 1'b0;
                    if (gap > 0) gap--;
                end
            end else begin
                req_valid = fast ? 1'b0 : 1'($urandom % 2);   // ignored while busy (R8)
                req_vaddr = $urandom;
                root_base = $urandom;
            end

            // advance the model across the coming edge
            case (step)
                0: if (req_valid) begin
                       m_va = req_vaddr; m_base = root_base; step = 1;
                   end
                1: if (mem_req_ready) step = 2;
                2: if (mem_rsp_valid) begin
                       if (mem_rsp_data[0]) begin m_tbl = mem_rsp_data; step = 3; end
                       else begin m_lvl = 1'b0; step = 6; end
                   end
                3: if (mem_req_ready) step = 4;
                4: if (mem_rsp_valid) begin
                       if (mem_rsp_data[0]) begin m_frame = mem_rsp_data; step = 5; end
                       else begin m_lvl = 1'b1; step = 6; end
                   end
                default: begin done_jobs++; step = 0; end
            endcase
            spur_prev = spur_now;
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule